// File: doc/BRIEF.md
# I2C High-Speed Mode Tracker

This block watches the two lines of an I2C bus from the target side. Both lines come in from the pins without any timing relation to the system clock. The block samples them with a fast system clock and finds the bus conditions: START, repeated START and STOP. It also looks at the first byte of each transfer. When that byte is the high-speed master code, the block moves a mode flag from fast-speed to high-speed. The rest of the device reads this flag to choose its timing.

After the master code, the block holds off the acknowledge, so the code is always answered with a NACK. High-speed mode starts on the tenth rising SCL edge counted from the START. Repeated STARTs keep the bus in high-speed mode. Any STOP returns the bus to fast-speed mode. Any other first byte is handed on as an address byte together with a strobe, and this works the same way in both speed modes.

Top module: `hsmode_tracker`

## Requirements
- R1: SDA falling while SCL is high, with no transfer open, produces a one-cycle `start_pulse` and opens a transfer.
- R2: SDA falling while SCL is high, with a transfer already open, produces a one-cycle `rstart_pulse` and no `start_pulse`.
- R3: SDA rising while SCL is high produces a one-cycle `stop_pulse` and closes the open transfer.
- R4: In fast-speed mode, a first byte after a START or repeated START is the master code when its upper five bits, received MSB first, are 00001. The lower three bits are ignored. A master code produces one `mcode_pulse`.
- R5: `ack_inhibit` is 1 from the 8th rising SCL edge of a master-code frame until its 10th rising edge. It is 1 during the ninth (acknowledge) clock only for a master code and never for an address byte.
- R6: `hs_mode` (1 = high-speed, 0 = fast-speed) changes to 1 on the 10th rising SCL edge after the START that opened the master-code frame, and not earlier.
- R7: A repeated START while `hs_mode` is 1 leaves `hs_mode` at 1.
- R8: A STOP clears `hs_mode` to 0.
- R9: A first byte that is not recognised as a master code produces `addr_valid` for one cycle, with the byte on `addr_byte` (MSB first), and leaves `hs_mode` unchanged. In high-speed mode, every first byte is reported this way, even one whose upper five bits are 00001.
- R10: After reset, `hs_mode`, `ack_inhibit` and every pulse output are 0.
- R11: Bytes that follow the first byte of a transfer produce neither `addr_valid` nor `mcode_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| hs_mode | output | 1 | 1 = high-speed mode, 0 = fast-speed mode |
| start_pulse | output | 1 | START detected |
| rstart_pulse | output | 1 | Repeated START detected |
| stop_pulse | output | 1 | STOP detected |
| mcode_pulse | output | 1 | Master code received |
| addr_valid | output | 1 | First byte of a transfer is on addr_byte |
| addr_byte | output | 8 | First byte received, MSB first |
| ack_inhibit | output | 1 | Target must leave SDA released in the acknowledge slot |

## Verification
The assertions check on every cycle that:
- at most one event strobe is active at a time;
- a repeated START never changes the mode;
- a STOP always leaves fast-speed mode;
- a master code is only seen in fast-speed mode;
- high-speed mode only starts at the end of an inhibited acknowledge slot.

Only the bench scenarios can show the edge on which the mode changes, the bits that are ignored in the code, and that a byte with the code pattern is treated as an address in high-speed mode. They also show that data bytes raise no strobe and that the whole order of events matches the bus activity that was driven.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef struct packed {
        logic              sda_p;
        logic              scl_p;
    } cond_t;

    typedef struct packed {
        logic              busy;
        logic              first;
        logic              mcode;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic              hs;
        logic              start_p;
        logic              rstart_p;
        logic              stop_p;
        logic              mcode_p;
        logic              addr_p;
        logic [BYTE_W-1:0] addr;
    } trk_t;
endpackage

// File: rtl/hsm_sync.sv
module hsm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hsm_cond_detect.sv
module hsm_cond_detect
    import hsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_s,
    output logic start_cond,
    output logic stop_cond,
    output logic scl_rise
);
    cond_t st_d, st_q;

    always_comb begin
        st_d.sda_p = sda_s;
        st_d.scl_p = scl_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sda_p: 1'b1, scl_p: 1'b1};
        else        st_q <= st_d;
    end

    assign start_cond = scl_s & st_q.scl_p & st_q.sda_p & ~sda_s;
    assign stop_cond  = scl_s & st_q.scl_p & ~st_q.sda_p & sda_s;
    assign scl_rise   = scl_s & ~st_q.scl_p;
endmodule

// File: rtl/hsm_frame_track.sv
module hsm_frame_track
    import hsm_pkg::*;
#(
    parameter int                PREFIX_W     = 5,
    parameter logic [PREFIX_W-1:0] MCODE_PREFIX = 5'b00001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cond,
    input  logic              stop_cond,
    input  logic              scl_rise,
    input  logic              sda_lvl,
    output logic              hs_mode,
    output logic              start_pulse,
    output logic              rstart_pulse,
    output logic              stop_pulse,
    output logic              mcode_pulse,
    output logic              addr_valid,
    output logic [BYTE_W-1:0] addr_byte,
    output logic              ack_inhibit
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] HS_EDGE  = CNT_W'(BYTE_W + 1);

    trk_t st_d, st_q;
    logic [BYTE_W-1:0] nbyte;

    always_comb begin
        st_d          = st_q;
        st_d.start_p  = 1'b0;
        st_d.rstart_p = 1'b0;
        st_d.stop_p   = 1'b0;
        st_d.mcode_p  = 1'b0;
        st_d.addr_p   = 1'b0;
        nbyte         = {st_q.shreg[BYTE_W-2:0], sda_lvl};

        if (stop_cond) begin
            st_d.busy   = 1'b0;
            st_d.first  = 1'b0;
            st_d.mcode  = 1'b0;
            st_d.hs     = 1'b0;
            st_d.stop_p = 1'b1;
        end else if (start_cond) begin
            st_d.rstart_p = st_q.busy;
            st_d.start_p  = ~st_q.busy;
            st_d.busy     = 1'b1;
            st_d.first    = 1'b1;
            st_d.mcode    = 1'b0;
            st_d.bitcnt   = '0;
        end else if (scl_rise && st_q.busy && (st_q.first || st_q.mcode)) begin
            if (st_q.bitcnt < ACK_SLOT) begin
                st_d.shreg  = nbyte;
                st_d.bitcnt = st_q.bitcnt + 1'b1;
                if (st_q.bitcnt == LAST_BIT) begin
                    st_d.first = 1'b0;
                    if (!st_q.hs &&
                        nbyte[BYTE_W-1 -: PREFIX_W] == MCODE_PREFIX) begin
                        st_d.mcode   = 1'b1;
                        st_d.mcode_p = 1'b1;
                    end else begin
                        st_d.addr_p = 1'b1;
                        st_d.addr   = nbyte;
                    end
                end
            end else if (st_q.bitcnt == ACK_SLOT) begin
                st_d.bitcnt = HS_EDGE;
            end else begin
                st_d.hs    = 1'b1;
                st_d.mcode = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_mode      = st_q.hs;
    assign start_pulse  = st_q.start_p;
    assign rstart_pulse = st_q.rstart_p;
    assign stop_pulse   = st_q.stop_p;
    assign mcode_pulse  = st_q.mcode_p;
    assign addr_valid   = st_q.addr_p;
    assign addr_byte    = st_q.addr;
    assign ack_inhibit  = st_q.mcode && (st_q.bitcnt >= ACK_SLOT);
endmodule

// File: rtl/hsmode_tracker.sv
module hsmode_tracker #(
    parameter int SYNC_STAGES = 2,
    parameter int PREFIX_W    = 5,
    parameter logic [PREFIX_W-1:0] MCODE_PREFIX = 5'b00001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_in,
    input  logic       scl_in,
    output logic       hs_mode,
    output logic       start_pulse,
    output logic       rstart_pulse,
    output logic       stop_pulse,
    output logic       mcode_pulse,
    output logic       addr_valid,
    output logic [7:0] addr_byte,
    output logic       ack_inhibit
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, syn_lines;
    logic start_cond, stop_cond, scl_rise;

    assign raw_lines = {scl_in, sda_in};

    for (genvar i = 0; i < NLINES; i++) begin : g_sync
        hsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lines[i]),
            .q     (syn_lines[i])
        );
    end

    hsm_cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (syn_lines[0]),
        .scl_s      (syn_lines[1]),
        .start_cond (start_cond),
        .stop_cond  (stop_cond),
        .scl_rise   (scl_rise)
    );

    hsm_frame_track #(.PREFIX_W(PREFIX_W), .MCODE_PREFIX(MCODE_PREFIX)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_cond   (start_cond),
        .stop_cond    (stop_cond),
        .scl_rise     (scl_rise),
        .sda_lvl      (syn_lines[0]),
        .hs_mode      (hs_mode),
        .start_pulse  (start_pulse),
        .rstart_pulse (rstart_pulse),
        .stop_pulse   (stop_pulse),
        .mcode_pulse  (mcode_pulse),
        .addr_valid   (addr_valid),
        .addr_byte    (addr_byte),
        .ack_inhibit  (ack_inhibit)
    );
endmodule

// File: rtl/hsmode_tracker_chk.sv
module hsmode_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_mode,
    input logic       start_pulse,
    input logic       rstart_pulse,
    input logic       stop_pulse,
    input logic       mcode_pulse,
    input logic       addr_valid,
    input logic       ack_inhibit
);
    // R1 R2 R3: bus events are exclusive
    a_r1_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, rstart_pulse, stop_pulse, mcode_pulse, addr_valid}));

    a_r7_rstart_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_pulse |-> $stable(hs_mode));

    a_r8_stop_leaves_fs: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !hs_mode);

    a_r4_mcode_only_in_fs: assert property (@(posedge clk) disable iff (!rst_n)
        mcode_pulse |-> !hs_mode);

    a_r6_hs_after_nack_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> $past(ack_inhibit));

    a_r5_inhibit_in_fs: assert property (@(posedge clk) disable iff (!rst_n)
        ack_inhibit |-> !hs_mode);
endmodule

bind hsmode_tracker hsmode_tracker_chk u_chk (.*);

// File: tb/hsmode_tracker_tb.sv
module hsmode_tracker_tb;
    localparam int HP = 8;
    localparam int EV_START = 1, EV_RSTART = 2, EV_STOP = 3, EV_MCODE = 4, EV_ADDR = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sda = 1'b1, scl = 1'b1;
    logic hs_mode, start_pulse, rstart_pulse, stop_pulse, mcode_pulse, addr_valid, ack_inhibit;
    logic [7:0] addr_byte;

    int checks = 0;
    int fails  = 0;
    int expq[$];

    always #2 clk = ~clk;

    hsmode_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .sda_in(sda), .scl_in(scl),
        .hs_mode(hs_mode), .start_pulse(start_pulse), .rstart_pulse(rstart_pulse),
        .stop_pulse(stop_pulse), .mcode_pulse(mcode_pulse), .addr_valid(addr_valid),
        .addr_byte(addr_byte), .ack_inhibit(ack_inhibit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bus_start();
        expq.push_back(EV_START * 256);
        sda = 1'b0; hold();
        scl = 1'b0; hold();
    endtask

    task automatic bus_rstart(input logic chk_hs, input logic exp_hs);
        expq.push_back(EV_RSTART * 256);
        sda = 1'b1; hold();
        scl = 1'b1; hold();
        if (chk_hs) chk("R6 mode after 10th rise", hs_mode, exp_hs);
        sda = 1'b0; hold();
        scl = 1'b0; hold();
        chk("R7 mode across Sr", hs_mode, exp_hs);
    endtask

    task automatic bus_stop();
        expq.push_back(EV_STOP * 256);
        sda = 1'b0; hold();
        scl = 1'b1; hold();
        sda = 1'b1; hold();
        chk("R8 mode after STOP", hs_mode, 0);
    endtask

    // kind: 0 data, 1 address, 2 master code
    task automatic send_byte(input logic [7:0] b, input int kind);
        if (kind == 1) expq.push_back(EV_ADDR * 256 + b);
        if (kind == 2) expq.push_back(EV_MCODE * 256);
        for (int i = 7; i >= 0; i--) begin
            sda = b[i]; hold();
            scl = 1'b1; hold();
            scl = 1'b0; hold();
        end
        sda = 1'b1; hold();
        scl = 1'b1; hold();
        chk("R5 ack_inhibit in ninth clock", ack_inhibit, (kind == 2) ? 1 : 0);
        if (kind == 2) chk("R6 mode not yet set at 9th rise", hs_mode, 0);
        scl = 1'b0; hold();
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (start_pulse | rstart_pulse | stop_pulse | mcode_pulse | addr_valid)) begin
                int obs;
                obs = start_pulse  ? EV_START * 256 :
                      rstart_pulse ? EV_RSTART * 256 :
                      stop_pulse   ? EV_STOP * 256 :
                      mcode_pulse  ? EV_MCODE * 256 : EV_ADDR * 256 + int'(addr_byte);
                if (expq.size() == 0) chk("R1 R2 R3 R4 R9 R11 unexpected event", obs, 0);
                else chk("R1 R2 R3 R4 R9 R11 event order", obs, expq.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R10 hs_mode reset", hs_mode, 0);
        chk("R10 pulses reset", {start_pulse, rstart_pulse, stop_pulse, mcode_pulse, addr_valid}, 0);
        chk("R10 ack_inhibit reset", ack_inhibit, 0);
        rst_n = 1'b1;
        hold();

        // FS write: address, data byte resembling code (R11), stop
        bus_start();
        send_byte(8'hA4, 1);
        chk("R9 mode kept after address", hs_mode, 0);
        send_byte(8'h0F, 0);
        bus_stop();

        // FS repeated start (R2)
        bus_start();
        send_byte(8'h30, 1);
        bus_rstart(1'b0, 1'b0);
        send_byte(8'h31, 1);
        bus_stop();

        // Master code 0x0D then HS transfers (R4 R5 R6 R7 R9 R8)
        bus_start();
        send_byte(8'h0D, 2);
        bus_rstart(1'b1, 1'b1);
        send_byte(8'h52, 1);
        send_byte(8'h0A, 0);
        bus_rstart(1'b0, 1'b1);
        send_byte(8'h0B, 1);
        chk("R9 code pattern in HS keeps mode", hs_mode, 1);
        bus_stop();

        // Low bits ignored: 0x08 and 0x0F (R4)
        bus_start();
        send_byte(8'h08, 2);
        bus_rstart(1'b1, 1'b1);
        bus_stop();
        bus_start();
        send_byte(8'h0F, 2);
        bus_rstart(1'b1, 1'b1);
        send_byte(8'h10, 1);
        bus_stop();

        // Near-miss byte 0x17 is an address (R4 R9)
        bus_start();
        send_byte(8'h17, 1);
        chk("R9 near-miss keeps FS", hs_mode, 0);
        bus_stop();

        hold();
        chk("R1 R3 all expected events seen", expq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule